// File: doc/BRIEF.md
# Latched Interrupt Request Flag Register

This block holds eight bits of latched interrupt requests for a small microcontroller. Four external pins can each raise a request. Each pin has its own enable for the interrupt function and its own choice of rising or falling edge. Two internal sources also raise requests: a one-cycle overflow pulse from a timer, and a one-cycle pulse from the sleep controller when a direct power-mode transition is carried out. Hardware sets a flag when its event happens. The flag then stays set until software clears it.

Software reads the register through a plain read strobe. It clears flags by writing a 0 to each bit it wants cleared. A 1 in any bit position of the written word leaves that flag as it was, so one flag can be cleared without a read-modify-write race. Two positions hold no flag: they always read 1 and ignore writes. A per-bit mask selects which set flags drive the single combined interrupt output. There is no data stream here, so every pin is a plain level or strobe with no handshake.

Bit layout of the register: bit 7 is the direct-transition flag, bit 6 is the timer overflow flag, bits 5 and 4 are reserved, and bits 3 to 0 are the flags for pins 3 to 0.

Top module: `irq_latch_reg`

## Requirements
- R1: After reset every flag is 0, `irq_o` is 0, and a read returns 8'h30.
- R2: Bits 5 and 4 of `rdata_o` read as 1 on every read, and writes never change them.
- R3: Bit 7 sets on the clock edge that samples `sleep_direct_i` high while `dt_en_i` is 1. With `dt_en_i` at 0 the pulse is ignored.
- R4: Bit 6 sets on the clock edge that samples `tmr_ovf_i` high.
- R5: Pin n sets bit n when the pin is enabled and its selected edge occurs. `pin_rise_i[n]`=1 selects the rising edge and 0 selects the falling edge. The opposite edge is ignored. The flag becomes visible after the third rising clock edge that follows the pin change (two synchroniser stages plus one edge-history stage).
- R6: While `pin_en_i[n]` is 0, edges on pin n never set bit n, and a bit n that is already set stays set.
- R7: A write with `wr_en_i` high clears every implemented flag whose `wdata_i` bit is 0. It leaves every flag whose `wdata_i` bit is 1 unchanged.
- R8: When a set event and a write of 0 reach the same flag in the same cycle, the flag ends up set.
- R9: `irq_o` is the OR over all bits of (flags AND `irq_mask_i`). It is combinational from the flag register and the mask.
- R10: While `rd_en_i` is high, `rdata_o` shows the current flags with bits 5 and 4 forced high. While `rd_en_i` is low, `rdata_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Asynchronous external interrupt pins |
| pin_en_i | input | 4 | Per-pin interrupt-function enable |
| pin_rise_i | input | 4 | Per-pin edge select, 1 = rising and 0 = falling |
| tmr_ovf_i | input | 1 | One-cycle timer overflow pulse |
| sleep_direct_i | input | 1 | One-cycle pulse when a direct mode transition is executed |
| dt_en_i | input | 1 | Direct-transition enable control |
| rd_en_i | input | 1 | Decoded read strobe |
| wr_en_i | input | 1 | Decoded write strobe |
| wdata_i | input | 8 | Write data, a 0 clears the matching flag |
| irq_mask_i | input | 8 | Per-bit mask for the combined interrupt |
| rdata_o | output | 8 | Read data |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that reserved bits read high, that the timer and direct-transition flags obey their set, clear and set-wins rules, that a disabled pin never raises a fresh flag, and that the interrupt output never rises with the flag register empty. Only the bench scenarios can show the three-edge pin latency, the selection of rising versus falling edges, and the full sweep of write values and mask values against arithmetically computed results. The bench also shows that a set pin flag survives its pin being disabled.

// File: rtl/irq_latch_pkg.sv
`timescale 1ns/1ps
package irq_latch_pkg;
  localparam int REG_W    = 8;
  localparam int NPIN     = 4;
  localparam int BIT_DT   = 7;
  localparam int BIT_TMR  = 6;
  localparam logic [REG_W-1:0] RSVD_MASK = 8'h30;
  localparam logic [REG_W-1:0] IMPL_MASK = ~RSVD_MASK;

  typedef struct packed {
    logic            dt;
    logic            tmr;
    logic [1:0]      rsvd;
    logic [NPIN-1:0] pin;
  } flag_vec_t;
endpackage

// File: rtl/irq_pin_sync.sv
`timescale 1ns/1ps
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o
);
  localparam int TOP = STAGES - 1;
  logic [TOP:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[TOP-1:0], pin_i};
      end
    end
  endgenerate

  assign lvl_o = chain_q[TOP];
endmodule

// File: rtl/irq_edge_det.sv
`timescale 1ns/1ps
module irq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic en_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  logic prev_q;
  logic rise_w;
  logic fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_w = lvl_i & ~prev_q;
  assign fall_w = ~lvl_i & prev_q;
  assign hit_o  = en_i & (rise_sel_i ? rise_w : fall_w);
endmodule

// File: rtl/irq_flag_bank.sv
`timescale 1ns/1ps
module irq_flag_bank
  import irq_latch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_i,
  input  logic [REG_W-1:0] clr_i,
  output logic [REG_W-1:0] flags_o
);
  logic [REG_W-1:0] flags_q;
  logic [REG_W-1:0] flags_d;

  // Set takes precedence: a clear only removes bits that are not being set.
  assign flags_d = (set_i | (flags_q & ~clr_i)) & IMPL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irq_latch_reg.sv
`timescale 1ns/1ps
module irq_latch_reg
  import irq_latch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pin_i,
  input  logic [NPIN-1:0]  pin_en_i,
  input  logic [NPIN-1:0]  pin_rise_i,
  input  logic             tmr_ovf_i,
  input  logic             sleep_direct_i,
  input  logic             dt_en_i,
  input  logic             rd_en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [REG_W-1:0] irq_mask_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [NPIN-1:0]  pin_lvl;
  logic [NPIN-1:0]  pin_hit;
  flag_vec_t        set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flag_q;

  genvar gi;
  generate
    for (gi = 0; gi < NPIN; gi++) begin : g_pin
      irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pin_i[gi]),
        .lvl_o (pin_lvl[gi])
      );
      irq_edge_det u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (pin_lvl[gi]),
        .en_i       (pin_en_i[gi]),
        .rise_sel_i (pin_rise_i[gi]),
        .hit_o      (pin_hit[gi])
      );
    end
  endgenerate

  always_comb begin
    set_vec      = '0;
    set_vec.dt   = sleep_direct_i & dt_en_i;
    set_vec.tmr  = tmr_ovf_i;
    set_vec.pin  = pin_hit;
  end

  assign clr_vec = wr_en_i ? ~wdata_i : '0;

  irq_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .flags_o (flag_q)
  );

  assign rdata_o = rd_en_i ? (flag_q | RSVD_MASK) : '0;
  assign irq_o   = |(flag_q & irq_mask_i);
endmodule

// File: rtl/irq_latch_chk.sv
`timescale 1ns/1ps
module irq_latch_chk
  import irq_latch_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NPIN-1:0]  pin_en_i,
  input logic             tmr_ovf_i,
  input logic             sleep_direct_i,
  input logic             dt_en_i,
  input logic             rd_en_i,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wdata_i,
  input logic [REG_W-1:0] flag_q,
  input logic [REG_W-1:0] rdata_o,
  input logic             irq_o
);
  p_rsvd_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |-> (rdata_o[5] && rdata_o[4]));

  p_dt_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(sleep_direct_i && dt_en_i) && !flag_q[BIT_DT]) |=> !flag_q[BIT_DT]);

  p_dt_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_direct_i && dt_en_i) |=> flag_q[BIT_DT]);

  p_tmr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_i |=> flag_q[BIT_TMR]);

  p_tmr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wdata_i[BIT_TMR] && !tmr_ovf_i) |=> !flag_q[BIT_TMR]);

  p_tmr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wdata_i[BIT_TMR] && flag_q[BIT_TMR]) |=> flag_q[BIT_TMR]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !wdata_i[BIT_TMR] && tmr_ovf_i) |=> flag_q[BIT_TMR]);

  p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag_q != '0));

  p_rd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (rdata_o == '0));

  genvar gp;
  generate
    for (gp = 0; gp < NPIN; gp++) begin : g_pin_chk
      p_pin_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_en_i[gp] && !flag_q[gp]) |=> !flag_q[gp]);
      p_pin_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[gp] && !wr_en_i) |=> flag_q[gp]);
    end
  endgenerate
endmodule

bind irq_latch_reg irq_latch_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .pin_en_i       (pin_en_i),
  .tmr_ovf_i      (tmr_ovf_i),
  .sleep_direct_i (sleep_direct_i),
  .dt_en_i        (dt_en_i),
  .rd_en_i        (rd_en_i),
  .wr_en_i        (wr_en_i),
  .wdata_i        (wdata_i),
  .flag_q         (flag_q),
  .rdata_o        (rdata_o),
  .irq_o          (irq_o)
);

// File: tb/sim_irq_latch_reg.sv
`timescale 1ns/1ps
module sim_irq_latch_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pin = '0, pin_en = '0, pin_rise = '0;
  logic       tmr_ovf = 1'b0, sleep_dir = 1'b0, dt_en = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wdata = '0, mask = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  irq_latch_reg u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .pin_en_i(pin_en), .pin_rise_i(pin_rise),
    .tmr_ovf_i(tmr_ovf), .sleep_direct_i(sleep_dir), .dt_en_i(dt_en),
    .rd_en_i(rd_en), .wr_en_i(wr_en), .wdata_i(wdata), .irq_mask_i(mask),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic read_reg(output logic [7:0] v);
    rd_en = 1'b1;
    #1;
    v = rdata;
    rd_en = 1'b0;
    #1;
  endtask

  task automatic write_reg(logic [7:0] v);
    wr_en = 1'b1;
    wdata = v;
    tick();
    wr_en = 1'b0;
    wdata = '0;
  endtask

  // Raises every implemented flag; pins are left low with rising edge selected.
  task automatic set_all();
    tmr_ovf = 1'b1; dt_en = 1'b1; sleep_dir = 1'b1;
    tick();
    tmr_ovf = 1'b0; sleep_dir = 1'b0; dt_en = 1'b0;
    pin_en = 4'hF; pin_rise = 4'hF; pin = 4'hF;
    tick(3);
    pin = 4'h0;
    tick(3);
    pin_en = 4'h0;
  endtask

  logic [7:0] v;

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();

    // R1 reset state, R10 idle read bus
    read_reg(v);
    check("R1 reset read", v, 8'h30);
    check("R1 reset irq", {7'b0, irq}, 8'h00);
    check("R10 idle rdata", rdata, 8'h00);

    // R2 reserved bits ignore writes; R7 write of ones leaves clear flags clear
    write_reg(8'hFF);
    read_reg(v);
    check("R2 after write FF", v, 8'h30);
    write_reg(8'h00);
    read_reg(v);
    check("R2 after write 00", v, 8'h30);

    // R3 direct transition gated by enable
    dt_en = 1'b0; sleep_dir = 1'b1; tick(); sleep_dir = 1'b0;
    read_reg(v);
    check("R3 disabled direct pulse", v, 8'h30);
    dt_en = 1'b1; sleep_dir = 1'b1; tick(); sleep_dir = 1'b0; dt_en = 1'b0;
    read_reg(v);
    check("R3 enabled direct pulse", v, 8'hB0);
    write_reg(8'h7F);
    read_reg(v);
    check("R7 clear bit7", v, 8'h30);

    // R4 timer
    tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    read_reg(v);
    check("R4 timer flag", v, 8'h70);

    // R8 set wins against same-cycle clear of everything
    tmr_ovf = 1'b1; wr_en = 1'b1; wdata = 8'h00; tick();
    tmr_ovf = 1'b0; wr_en = 1'b0;
    read_reg(v);
    check("R8 set wins", v, 8'h70);
    write_reg(8'h00);

    // R5/R6 pin sweep: every pin, both edges, enabled and disabled
    for (int p = 0; p < 4; p++) begin
      for (int sel = 0; sel < 2; sel++) begin
        for (int en = 0; en < 2; en++) begin
          pin_en = 4'h0;
          pin[p] = (sel == 1) ? 1'b0 : 1'b1;
          tick(4);
          write_reg(8'h00);
          pin_rise[p] = sel[0];
          pin_en[p] = en[0];
          pin[p] = ~pin[p];
          tick(2);
          read_reg(v);
          check("R5 latency not yet", v, 8'h30);
          tick();
          read_reg(v);
          check(en ? "R5 pin edge sets" : "R6 disabled pin ignored",
                v, 8'h30 | (en ? (8'h01 << p) : 8'h00));
          write_reg(8'h00);
          pin[p] = ~pin[p];
          tick(4);
          read_reg(v);
          check("R5 opposite edge ignored", v, 8'h30);
        end
      end
      pin[p] = 1'b0;
    end
    pin_en = 4'h0; pin_rise = 4'h0;
    tick(4);
    write_reg(8'h00);

    // R6 a set pin flag survives disabling and further edges
    pin_en = 4'h4; pin_rise = 4'h4; pin = 4'h4;
    tick(3);
    pin_en = 4'h0;
    pin = 4'h0; tick(3); pin = 4'h4; tick(4); pin = 4'h0; tick(4);
    read_reg(v);
    check("R6 flag held while disabled", v, 8'h34);
    write_reg(8'h00);

    // R7 sweep of every write value against all flags set
    for (int w = 0; w < 256; w++) begin
      set_all();
      read_reg(v);
      check("R7 all set", v, 8'hFF);
      write_reg(w[7:0]);
      read_reg(v);
      check("R7 selective clear", v, (8'hCF & w[7:0]) | 8'h30);
    end
    write_reg(8'h00);

    // R9 mask sweep over several flag patterns
    begin
      logic [7:0] pats [6] = '{8'hCF, 8'h80, 8'h40, 8'h08, 8'h01, 8'h00};
      foreach (pats[i]) begin
        set_all();
        write_reg(pats[i]);
        for (int m = 0; m < 256; m++) begin
          mask = m[7:0];
          #1;
          check("R9 combined irq", {7'b0, irq}, {7'b0, |(pats[i] & m[7:0])});
        end
        mask = '0;
        write_reg(8'h00);
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule